// File: doc/BRIEF.md
# Banked File Address and Status Register

This block turns the register-file operand of an instruction into a physical address in a 512-byte data memory split into four 128-byte banks, and it holds the processor status byte whose top bits choose the bank. A direct access joins the two direct bank bits of the status byte with the 7-bit operand offset. When the operand names offset 00h, the access is indirect: the physical address is then the 8-bit pointer value with the indirect bank bit of the status byte above it.

A handful of core offsets are shared by all four banks, so that any access to them, direct or indirect, lands on the single copy in bank 0. If an indirect access uses a pointer that again selects offset 00h, the block raises a read-zero flag so the data path returns 00h, and a write-suppress flag so nothing is stored.

The status byte is written like any other location, but its timeout and power-down bits only follow the sleep, watchdog-clear and watchdog-timeout events, and the zero, digit-carry and carry bits take the ALU result whenever the ALU asks to update them, even if the same instruction is writing the status byte. For subtraction the ALU supplies the carry and digit-carry as inverted borrows; the block stores whatever it is given.

Top module: `banked_file_addr`

## Requirements
- R1: After reset the status byte reads 0x18 (bit 7 indirect bank, bits 6:5 direct bank, bit 4 timeout flag, bit 3 power-down flag, bit 2 Z, bit 1 DC, bit 0 C).
- R2: For a non-zero operand offset outside the shared set, phys_addr equals {status bit 6, status bit 5, op_field}, so each bank spans 128 bytes.
- R3: When op_field is 00h, phys_addr equals {status bit 7, ptr_val}.
- R4: An indirect access whose pointer has bits 6:0 equal to zero drives rd_zero and wr_block high in the same cycle, and a write during it leaves the status byte unchanged.
- R5: Offsets 00h, 02h, 03h, 04h, 0Ah and 0Bh map to bank 0 (phys_addr bits 8:7 zero) whatever the bank bits, for direct and indirect accesses alike.
- R6: An access with acc_wr high whose phys_addr is 003h loads status bits 7:5 and 2:0 from wr_data at the next clock edge; bits 4:3 are never changed by such a write.
- R7: When alu_upd bit i is high (bit 2 Z, bit 1 DC, bit 0 C), status bit i takes alu_flags bit i at the next edge, overriding any write data for that bit and also updating without a write.
- R8: A sleep event sets the timeout bit and clears the power-down bit; a watchdog-clear event sets both.
- R9: A watchdog timeout clears the timeout bit, leaves the power-down bit as it was, and wins over a sleep or watchdog-clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_field | input | 7 | Register offset from the instruction |
| ptr_val | input | 8 | Current value of the indirect pointer |
| acc_wr | input | 1 | The current access writes its target |
| wr_data | input | 8 | Data written by the current access |
| alu_flags | input | 3 | ALU results for Z, DC, C (bits 2,1,0) |
| alu_upd | input | 3 | Per-flag update enables, same order |
| evt_sleep | input | 1 | Sleep instruction executed |
| evt_wdt_clr | input | 1 | Watchdog-clear instruction executed |
| evt_wdt_to | input | 1 | Watchdog timeout occurred |
| phys_addr | output | 9 | Physical data-memory address |
| rd_zero | output | 1 | Read data must be forced to 00h |
| wr_block | output | 1 | Write must be discarded |
| status_q | output | 8 | Status byte |

## Verification
The bench builds the block with its default parameters: a 7-bit offset, an 8-bit pointer and the six-entry shared offset set with folding enabled. With these values all four banks are reachable by both the direct and the indirect path, the status byte can be written through an indirect pointer into a non-zero bank that folds back to 003h, and the self-referencing pointer can be tried both as 00h and as 80h.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
   localparam int BANK_BITS = 2;
   localparam int STAT_W    = 8;

   // Bit positions inside the status byte; neighbours decode these.
   localparam int SB_IRP = 7;
   localparam int SB_RP1 = 6;
   localparam int SB_RP0 = 5;
   localparam int SB_TO  = 4;
   localparam int SB_PD  = 3;
   localparam int SB_Z   = 2;
   localparam int SB_DC  = 1;
   localparam int SB_C   = 0;

   localparam logic [STAT_W-1:0] STAT_RST = 8'b0001_1000;

   typedef enum logic [1:0] {
      EV_NONE,
      EV_CLEAR,
      EV_SLEEP,
      EV_TIMEOUT
   } pwr_evt_t;
endpackage

// File: rtl/bfa_addr_map.sv
module bfa_addr_map
   import bfa_pkg::*;
#(
   parameter int OFF_W     = 7,
   parameter int PTR_W     = 8,
   parameter int INDIR_OFF = 0,
   parameter bit FOLD_EN   = 1'b1,
   parameter logic [(1<<OFF_W)-1:0] SHARED_SET = 'h0C1D,
   localparam int ADDR_W   = OFF_W + BANK_BITS
) (
   input  logic [OFF_W-1:0]     op_field,
   input  logic [PTR_W-1:0]     ptr_val,
   input  logic                 irp,
   input  logic [BANK_BITS-1:0] rp,
   output logic [ADDR_W-1:0]    phys_addr,
   output logic                 self_ref
);
   localparam logic [OFF_W-1:0] IND_OFF_V = OFF_W'(INDIR_OFF);

   logic              is_ind;
   logic [ADDR_W-1:0] raw_addr;
   logic [OFF_W-1:0]  raw_off;

   generate
      if (PTR_W + 1 != ADDR_W) begin : g_bad_width
         $error("pointer width must be one less than the address width");
      end
   endgenerate

   always_comb begin
      is_ind   = (op_field == IND_OFF_V);
      raw_addr = is_ind ? {irp, ptr_val} : {rp, op_field};
      raw_off  = raw_addr[OFF_W-1:0];
      self_ref = is_ind && (raw_off == IND_OFF_V);
   end

   generate
      if (FOLD_EN) begin : g_fold
         always_comb begin
            if (SHARED_SET[raw_off])
               phys_addr = {{BANK_BITS{1'b0}}, raw_off};
            else
               phys_addr = raw_addr;
         end
      end else begin : g_flat
         always_comb phys_addr = raw_addr;
      end
   endgenerate
endmodule

// File: rtl/bfa_status_reg.sv
module bfa_status_reg
   import bfa_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   input  logic [2:0]        alu_flags,
   input  logic [2:0]        alu_upd,
   input  logic              evt_sleep,
   input  logic              evt_wdt_clr,
   input  logic              evt_wdt_to,
   output logic [STAT_W-1:0] status_q
);
   logic [STAT_W-1:0] st_nxt;
   logic [2:0]        flag_nxt;
   logic [1:0]        topd_nxt;
   pwr_evt_t          evt;

   // Flag bits: ALU update beats explicit write data.
   generate
      for (genvar g = 0; g < 3; g++) begin : g_flag
         assign flag_nxt[g] = alu_upd[g] ? alu_flags[g]
                            : (wr_en ? wr_data[g] : status_q[g]);
      end
   endgenerate

   always_comb begin
      if (evt_wdt_to)       evt = EV_TIMEOUT;
      else if (evt_sleep)   evt = EV_SLEEP;
      else if (evt_wdt_clr) evt = EV_CLEAR;
      else                  evt = EV_NONE;
   end

   always_comb begin
      topd_nxt = status_q[SB_TO:SB_PD];
      unique case (evt)
         EV_TIMEOUT: topd_nxt[1] = 1'b0;
         EV_SLEEP:   topd_nxt    = 2'b10;
         EV_CLEAR:   topd_nxt    = 2'b11;
         default:    topd_nxt    = status_q[SB_TO:SB_PD];
      endcase
   end

   always_comb begin
      st_nxt = status_q;
      if (wr_en) st_nxt[SB_IRP:SB_RP0] = wr_data[SB_IRP:SB_RP0];
      st_nxt[SB_TO:SB_PD] = topd_nxt;
      st_nxt[SB_Z:SB_C]   = flag_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= STAT_RST;
      else        status_q <= st_nxt;
   end

   AST_TOPD_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !evt_sleep && !evt_wdt_clr && !evt_wdt_to) |=> status_q[SB_TO:SB_PD] == $past(status_q[SB_TO:SB_PD])); // R6
   AST_BANK_BITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> status_q[SB_IRP:SB_RP0] == $past(wr_data[SB_IRP:SB_RP0])); // R6
   AST_ZERO_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      alu_upd[2] |=> status_q[SB_Z] == $past(alu_flags[2])); // R7
   AST_CARRY_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      alu_upd[0] |=> status_q[SB_C] == $past(alu_flags[0])); // R7
   AST_SLEEP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sleep && !evt_wdt_to) |=> status_q[SB_TO:SB_PD] == 2'b10); // R8
   AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_wdt_clr && !evt_sleep && !evt_wdt_to) |=> status_q[SB_TO:SB_PD] == 2'b11); // R8
   AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_wdt_to |=> (!status_q[SB_TO] && status_q[SB_PD] == $past(status_q[SB_PD]))); // R9
endmodule

// File: rtl/banked_file_addr.sv
module banked_file_addr
   import bfa_pkg::*;
#(
   parameter int OFF_W      = 7,
   parameter int PTR_W      = 8,
   parameter int INDIR_OFF  = 0,
   parameter int STATUS_OFF = 3,
   parameter bit FOLD_EN    = 1'b1,
   parameter logic [(1<<OFF_W)-1:0] SHARED_SET = 'h0C1D,
   localparam int ADDR_W    = OFF_W + BANK_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFF_W-1:0]  op_field,
   input  logic [PTR_W-1:0]  ptr_val,
   input  logic              acc_wr,
   input  logic [STAT_W-1:0] wr_data,
   input  logic [2:0]        alu_flags,
   input  logic [2:0]        alu_upd,
   input  logic              evt_sleep,
   input  logic              evt_wdt_clr,
   input  logic              evt_wdt_to,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              rd_zero,
   output logic              wr_block,
   output logic [STAT_W-1:0] status_q
);
   localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFF);

   generate
      if (STATUS_OFF == INDIR_OFF) begin : g_bad_off
         $error("status offset must differ from the indirect offset");
      end
      if (FOLD_EN && !SHARED_SET[STATUS_OFF]) begin : g_bad_set
         $error("status offset must be shared by all banks");
      end
   endgenerate

   logic self_ref;
   logic stat_wr;

   bfa_addr_map #(
      .OFF_W(OFF_W), .PTR_W(PTR_W), .INDIR_OFF(INDIR_OFF),
      .FOLD_EN(FOLD_EN), .SHARED_SET(SHARED_SET)
   ) u_map (
      .op_field (op_field),
      .ptr_val  (ptr_val),
      .irp      (status_q[SB_IRP]),
      .rp       (status_q[SB_RP1:SB_RP0]),
      .phys_addr(phys_addr),
      .self_ref (self_ref)
   );

   assign rd_zero  = self_ref;
   assign wr_block = self_ref;
   assign stat_wr  = acc_wr && !self_ref && (phys_addr == STATUS_ADDR);

   bfa_status_reg u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (stat_wr),
      .wr_data    (wr_data),
      .alu_flags  (alu_flags),
      .alu_upd    (alu_upd),
      .evt_sleep  (evt_sleep),
      .evt_wdt_clr(evt_wdt_clr),
      .evt_wdt_to (evt_wdt_to),
      .status_q   (status_q)
   );

   AST_SELF_REF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_field == OFF_W'(INDIR_OFF) && ptr_val[OFF_W-1:0] == OFF_W'(INDIR_OFF)) |-> (rd_zero && wr_block)); // R4
   AST_SELF_REF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_zero && acc_wr && alu_upd == 3'b000 && !evt_sleep && !evt_wdt_clr && !evt_wdt_to) |=> $stable(status_q)); // R4
   AST_STATUS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_field == OFF_W'(STATUS_OFF)) |-> (phys_addr == STATUS_ADDR)); // R5
   AST_DIRECT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (op_field != OFF_W'(INDIR_OFF) && !SHARED_SET[op_field]) |-> (phys_addr[ADDR_W-1 -: BANK_BITS] == status_q[SB_RP1:SB_RP0])); // R2
endmodule

// File: tb/tb_banked_file_addr.sv
module tb_banked_file_addr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] op_field = '0;
   logic [7:0] ptr_val = '0;
   logic       acc_wr = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] alu_flags = '0;
   logic [2:0] alu_upd = '0;
   logic       evt_sleep = 1'b0;
   logic       evt_wdt_clr = 1'b0;
   logic       evt_wdt_to = 1'b0;
   logic [8:0] phys_addr;
   logic       rd_zero;
   logic       wr_block;
   logic [7:0] status_q;

   banked_file_addr dut (
      .clk(clk), .rst_n(rst_n), .op_field(op_field), .ptr_val(ptr_val),
      .acc_wr(acc_wr), .wr_data(wr_data), .alu_flags(alu_flags),
      .alu_upd(alu_upd), .evt_sleep(evt_sleep), .evt_wdt_clr(evt_wdt_clr),
      .evt_wdt_to(evt_wdt_to), .phys_addr(phys_addr), .rd_zero(rd_zero),
      .wr_block(wr_block), .status_q(status_q)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      int         due;
      bit         is_stat;
      logic [8:0] addr;
      logic       rz;
      logic       wb;
      logic [7:0] st;
      string      tag;
   } item_t;

   item_t      sb_q[$];
   int         cyc = 0;
   int         n_chk = 0;
   int         n_fail = 0;
   logic [7:0] exp_st = 8'h18;
   bit         done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: pops every expectation due in the current cycle.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (it.is_stat) begin
               if (status_q !== it.st) begin
                  n_fail++;
                  $display("FAIL %s status actual=%h expected=%h", it.tag, status_q, it.st);
               end
            end else if (phys_addr !== it.addr || rd_zero !== it.rz || wr_block !== it.wb) begin
               n_fail++;
               $display("FAIL %s addr/rz/wb actual=%h/%b/%b expected=%h/%b/%b",
                        it.tag, phys_addr, rd_zero, wr_block, it.addr, it.rz, it.wb);
            end
         end
      end
   end

   function automatic bit shared(input logic [6:0] off);
      return off == 7'h00 || off == 7'h02 || off == 7'h03 ||
             off == 7'h04 || off == 7'h0A || off == 7'h0B;
   endfunction

   // Driver: applies one access, pushes address and next-status expectations.
   task automatic step(input logic [6:0] op, input logic [7:0] ptr,
                       input logic wr, input logic [7:0] wd,
                       input logic [2:0] fv, input logic [2:0] fu,
                       input logic slp, input logic clr, input logic to,
                       input string tag);
      item_t      a;
      item_t      s;
      logic [8:0] ad;
      logic       self;
      logic       stw;
      logic [7:0] ns;
      @(negedge clk);
      op_field = op; ptr_val = ptr; acc_wr = wr; wr_data = wd;
      alu_flags = fv; alu_upd = fu;
      evt_sleep = slp; evt_wdt_clr = clr; evt_wdt_to = to;
      ad   = (op == 7'h00) ? {exp_st[7], ptr} : {exp_st[6:5], op};
      if (shared(ad[6:0])) ad[8:7] = 2'b00;
      self = (op == 7'h00) && (ptr[6:0] == 7'h00);
      stw  = wr && !self && ad == 9'h003;
      ns   = exp_st;
      if (stw) ns[7:5] = wd[7:5];
      for (int i = 0; i < 3; i++)
         ns[i] = fu[i] ? fv[i] : (stw ? wd[i] : exp_st[i]);
      if (to)       ns[4]   = 1'b0;
      else if (slp) ns[4:3] = 2'b10;
      else if (clr) ns[4:3] = 2'b11;
      a = '{due: cyc, is_stat: 1'b0, addr: ad, rz: self, wb: self, st: 8'h00, tag: tag};
      s = '{due: cyc + 1, is_stat: 1'b1, addr: 9'h0, rz: 1'b0, wb: 1'b0, st: ns, tag: tag};
      sb_q.push_back(a);
      sb_q.push_back(s);
      exp_st = ns;
   endtask

   initial begin
      item_t r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      r = '{due: cyc, is_stat: 1'b1, addr: 9'h0, rz: 1'b0, wb: 1'b0, st: 8'h18, tag: "R1"};
      sb_q.push_back(r);
      step(7'h20, 8'h00, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R2 bank0 direct");
      step(7'h03, 8'h00, 1, 8'h67, 3'b000, 3'b000, 0, 0, 0, "R6 write bank bits");
      step(7'h20, 8'h00, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R2 bank3 direct");
      step(7'h04, 8'h00, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R5 pointer offset folds");
      step(7'h0B, 8'h00, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R5 int ctrl folds");
      step(7'h0C, 8'h00, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R2 unshared stays in bank");
      step(7'h03, 8'h00, 1, 8'hE0, 3'b000, 3'b000, 0, 0, 0, "R6 set IRP");
      step(7'h00, 8'h45, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R3 indirect upper half");
      step(7'h00, 8'h80, 1, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R4 self ref 80h");
      step(7'h00, 8'h00, 1, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R4 self ref 00h");
      step(7'h00, 8'h83, 1, 8'h07, 3'b000, 3'b000, 0, 0, 0, "R5 indirect status write");
      step(7'h00, 8'h45, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R3 indirect lower half");
      step(7'h03, 8'h00, 1, 8'h05, 3'b000, 3'b100, 0, 0, 0, "R7 Z update beats write");
      step(7'h03, 8'h00, 1, 8'h00, 3'b100, 3'b100, 0, 0, 0, "R7 clear with Z set");
      step(7'h30, 8'h00, 0, 8'h00, 3'b001, 3'b001, 0, 0, 0, "R7 C update alone");
      step(7'h30, 8'h00, 0, 8'h00, 3'b000, 3'b000, 1, 0, 0, "R8 sleep");
      step(7'h30, 8'h00, 0, 8'h00, 3'b000, 3'b000, 0, 0, 1, "R9 timeout");
      step(7'h30, 8'h00, 0, 8'h00, 3'b000, 3'b000, 0, 1, 0, "R8 watchdog clear");
      step(7'h30, 8'h00, 0, 8'h00, 3'b000, 3'b000, 1, 0, 1, "R9 timeout beats sleep");
      step(7'h03, 8'h00, 1, 8'h18, 3'b000, 3'b000, 0, 0, 0, "R6 TO PD immune");
      step(7'h10, 8'h00, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "idle");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule